// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how long a fan takes to turn. A tachometer line from the fan is brought into the system clock domain. A counter then advances once for every pulse of a slow reference tick, nominally 90 kHz. The interval it measures runs from one latch to the next, and a latch happens on every second rising edge of the tachometer line. At each latch the count is copied into a 16-bit reading and the counter starts again from zero. A larger reading therefore means a slower fan.

A fan that has stopped produces no edges, so the counter keeps going until it reaches FFFFh. It stops there and does not roll over. When it reaches that value the reading is forced to FFFFh and a stall flag is raised. The reading is compared with a programmable minimum. A reading above the minimum raises the fail flag, and a reading at or below it raises the in-range flag. Fan spin-up logic uses the in-range flag to know when it may stop driving the fan at full speed. The reading always shows the real measured value, including during spin-up. The minimum must be programmed below FFFFh, so that a stalled fan can never look in range.

Top module: `tach_period_meter`

## Requirements
- R1: The tachometer input passes through a two-flop synchronizer. Only every second synchronized rising edge since reset causes a latch (the 2nd, 4th, 6th, ...). The other rising edges leave the reading unchanged.
- R2: At a latch, the reading takes the number of reference-tick cycles counted since the previous latch (or since reset), and the counter restarts from zero.
- R3: The counter stops at FFFFh and never wraps. Ticks that arrive while it is saturated leave it at FFFFh, so the next latch again yields FFFFh.
- R4: When the counter reaches FFFFh, the reading is set to FFFFh and stall goes to 1 without waiting for a tachometer edge.
- R5: Stall returns to 0 only when a latch captures a count below FFFFh.
- R6: fan_fail is 1 exactly when the reading is strictly greater than min_limit. A reading equal to min_limit is not a failure.
- R7: in_range is 1 exactly when the reading is less than or equal to min_limit.
- R8: fan_fail is a level, not a pulse. It stays at 1 for as long as the reading stays above min_limit, however much time passes. It follows changes to min_limit without waiting for a new reading.
- R9: After reset the reading is 0, stall is 0, fan_fail is 0 and in_range is 1.
- R10: Reference ticks between latches do not change the reading until the next latch or saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tach_in | input | 1 | Raw tachometer line from the fan, asynchronous to clk |
| ref_tick | input | 1 | One-cycle enable at the reference rate; the counter advances on each cycle it is high |
| min_limit | input | 16 | Programmed minimum; a reading above it is a failure |
| reading | output | 16 | Latched period count |
| stall | output | 1 | Counter reached FFFFh; the fan is considered stopped |
| fan_fail | output | 1 | Reading above min_limit |
| in_range | output | 1 | Reading at or below min_limit; used to end spin-up |

## Verification
Suppose tach_in rises before clock edge k. The two synchronizer flops hold it at edges k and k+1. The rise is therefore seen during the cycle after k+1, and on a latching edge the reading and stall change at edge k+2. A reference tick that is high before an edge is counted at that edge. A reading that reaches FFFFh through saturation appears one edge after the counter gets there. fan_fail and in_range are combinational from the reading and min_limit, so they are valid in the same cycle. The bench drives ticks only while the tachometer line is quiet, holds every tachometer level for four cycles, and samples on falling edges after those windows, so every result is already settled when it is read.

// File: rtl/tach_pkg.sv
// Shared constants for the tachometer period counter.
// Assumes the reading width is the same everywhere in the block.
package tach_pkg;
    parameter int TACH_CNT_W = 16;
    parameter int TACH_SYNC_STAGES = 2;
endpackage

// File: rtl/tach_edge_pair.sv
// Brings the raw tachometer line into the clk domain and finds its rising edges.
// Raises latch_evt on every second rising edge seen since reset.
// Assumes each tachometer level lasts at least two clk cycles.
module tach_edge_pair #(
    parameter int STAGES = tach_pkg::TACH_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise,
    output logic latch_evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              half_q;

    // Synchronizer shift chain plus a copy of the last synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tach_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise      = sync_q[STAGES-1] & ~prev_q;
    assign latch_evt = rise & half_q;

    // Tracks which rising edge of the pair comes next.
    always_ff @(posedge clk) begin
        if (!rst_n)    half_q <= 1'b0;
        else if (rise) half_q <= ~half_q;
    end

    assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_latch_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        latch_evt |=> !half_q);
endmodule

// File: rtl/tach_ref_counter.sv
// Counts reference ticks and stops at the all-ones value.
// A clear has priority over a tick that arrives in the same cycle.
module tach_ref_counter #(
    parameter int CNT_W = tach_pkg::TACH_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign sat = (cnt == CNT_MAX);

    // Saturating up-counter, cleared at each latch.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (tick && !sat) cnt <= cnt + 1'b1;
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> sat);
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/tach_reading_reg.sv
// Holds the latched period, the stall flag and the limit comparison.
// Assumes min_limit is stable or changes only under software control.
module tach_reading_reg #(
    parameter int CNT_W = tach_pkg::TACH_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_evt,
    input  logic             sat,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] min_limit,
    output logic [CNT_W-1:0] reading,
    output logic             stall,
    output logic             fan_fail,
    output logic             in_range
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Capture the count on a latch; force all-ones on saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reading <= '0;
            stall   <= 1'b0;
        end else if (latch_evt) begin
            reading <= cnt;
            stall   <= sat;
        end else if (sat) begin
            reading <= CNT_MAX;
            stall   <= 1'b1;
        end
    end

    // Limit comparison, a level that follows the reading and the limit.
    always_comb begin
        fan_fail = (reading > min_limit);
        in_range = !fan_fail;
    end

    assert_stall_on_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sat |=> stall);
    assert_stall_reading_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (reading == CNT_MAX));
    assert_reading_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_evt && !sat) |=> $stable(reading));
endmodule

// File: rtl/tach_period_meter.sv
// Top level: synchronizer and edge pairing, reference counter, reading register.
// Expects ref_tick to be a one-cycle enable at the reference rate.
module tach_period_meter #(
    parameter int CNT_W  = tach_pkg::TACH_CNT_W,
    parameter int STAGES = tach_pkg::TACH_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] min_limit,
    output logic [CNT_W-1:0] reading,
    output logic             stall,
    output logic             fan_fail,
    output logic             in_range
);
    logic             rise;
    logic             latch_evt;
    logic [CNT_W-1:0] cnt;
    logic             sat;

    tach_edge_pair #(.STAGES(STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in),
        .rise(rise), .latch_evt(latch_evt)
    );

    tach_ref_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(latch_evt), .tick(ref_tick),
        .cnt(cnt), .sat(sat)
    );

    tach_reading_reg #(.CNT_W(CNT_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .sat(sat),
        .cnt(cnt), .min_limit(min_limit), .reading(reading),
        .stall(stall), .fan_fail(fan_fail), .in_range(in_range)
    );

    assert_latch_needs_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        latch_evt |-> rise);
    assert_fail_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (fan_fail || min_limit == '1));
endmodule

// File: tb/tach_period_meter_tb.sv
// Self-checking bench: directed corners plus randomized windows.
module tach_period_meter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tach_in = 1'b0;
    logic        ref_tick = 1'b0;
    logic [15:0] min_limit = 16'd100;
    logic [15:0] reading;
    logic        stall, fan_fail, in_range;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int          m_ticks = 0;
    bit          m_half = 1'b0;
    logic [15:0] m_read = 16'd0;
    bit          m_stall = 1'b0;

    always #4 clk = ~clk;

    tach_period_meter dut_i (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ref_tick(ref_tick),
        .min_limit(min_limit), .reading(reading), .stall(stall),
        .fan_fail(fan_fail), .in_range(in_range)
    );

    function automatic bit exp_fail(logic [15:0] r, logic [15:0] m);
        return r > m;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " reading"}, reading, m_read);
        check({req, " stall"}, stall, m_stall);
        check({req, " fan_fail R6"}, fan_fail, exp_fail(m_read, min_limit));
        check({req, " in_range R7"}, in_range, !exp_fail(m_read, min_limit));
    endtask

    task automatic add_tick_model();
        if (m_ticks < 65535) m_ticks++;
        if (m_ticks == 65535) begin
            m_read  = 16'hFFFF;
            m_stall = 1'b1;
        end
    endtask

    task automatic give_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
            add_tick_model();
        end
    endtask

    task automatic tach_pulse();
        @(negedge clk) tach_in = 1'b1;
        repeat (4) @(negedge clk);
        tach_in = 1'b0;
        repeat (4) @(negedge clk);
        if (m_half) begin
            m_read  = 16'(m_ticks);
            m_stall = (m_ticks == 65535);
            m_ticks = 0;
        end
        m_half = ~m_half;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset");

        // R1: first edge arms only; R10: ticks alone do not move the reading
        give_ticks(5);
        tach_pulse();
        check_all("R1 first edge no latch");
        give_ticks(7);
        check_all("R10 hold before latch");
        tach_pulse();
        check_all("R2 latch 12");

        // R6/R7 boundary around min_limit
        give_ticks(3); tach_pulse(); give_ticks(97); tach_pulse();
        check_all("R6 equal limit");
        check("R7 equal in_range", in_range, 1);
        min_limit = 16'd99;
        #1 check_all("R8 limit change");
        repeat (50) @(negedge clk);
        check("R8 fail persists", fan_fail, 1);
        min_limit = 16'd100;

        // R4/R3: stall by saturation, then more ticks do not wrap
        @(negedge clk) ref_tick = 1'b1;
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            add_tick_model();
        end
        ref_tick = 1'b0;
        @(negedge clk);
        check_all("R4 stall");
        give_ticks(10);
        tach_pulse();
        if (m_half) tach_pulse();
        check_all("R3 no wrap");
        check("R3 stall kept", stall, 1);

        // R5: a short window clears stall
        give_ticks(20); tach_pulse(); tach_pulse();
        check_all("R5 stall clears");
        check("R5 stall low", stall, 0);

        // Random windows
        for (int n = 0; n < 24; n++) begin
            min_limit = 16'($urandom_range(0, 400));
            give_ticks($urandom_range(0, 150));
            tach_pulse();
            check_all(m_half ? "R1 arm random" : "R2 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule